// File: doc/BRIEF.md
# Teletext page request matcher

This block holds one page request for one acquisition channel. For each incoming teletext page header it decides whether that header is the page the host asked for. The host fills eight request columns of five bits each. It does this through a byte-wide write stream. A beat flagged as the first of a burst names its start column. Each later beat in the same burst writes the next column. The header side presents already-decoded digits and a one-cycle valid strobe: magazine, page tens, page units, hours tens, hours units, minutes tens and minutes units.

Each of the seven request digits carries its own care flag. A digit whose flag is clear takes no part in the comparison. Because of this, one register set serves both plain page selection (only magazine and page digits cared) and timed selection (subcode digits cared as well). A hold control gates the capture-enable output, so a matching page can be frozen. The request also holds a subtitle flag, which can be written only while a mode input is high, and a three-bit chapter address. Both are brought out as plain outputs.

The write stream has no ready signal: every beat with `wr_valid` high is consumed in its cycle, so the host never sees back-pressure. Beats the block does not want are discarded, not stalled. The header stream also has no back-pressure: every strobe produces one result one cycle later.

Top module: `pgreq_matcher`

## Requirements
- R1: Reset clears all eight columns, so every care flag and the hold bit are 0. `match_o`, `capture_o`, `subtitle_o` and `chapter_o` are 0. A header strobed right after reset matches, because no digit is cared, but gives no capture.
- R2: A beat with `wr_valid` and `wr_start` both high writes `wr_data[4:0]` into column `wr_col`. Each later beat with `wr_valid` high and `wr_start` low writes the next higher column. Bits 7..5 of `wr_data` are ignored.
- R3: After column 7 has been written, further beats without `wr_start` are dropped and leave every column unchanged. A beat without `wr_start` that arrives before any burst has started after reset is dropped as well.
- R4: When `hdr_valid` is high in cycle N and every cared digit equals its header digit, `match_o` is 1 in cycle N+1.
- R5: A digit whose care flag (bit 4 of its column, columns 0 to 6) is 0 does not affect `match_o`, whatever its stored and header values.
- R6: A cared digit that differs from its header digit makes `match_o` 0 in the cycle after the strobe.
- R7: `capture_o` equals `match_o` AND the hold bit (column 0 bit 3) as it stood when the header was strobed. A hold bit of 0 blocks capture even on a match.
- R8: Column 3 bit 3 (subtitle) is stored only when the beat writing it sees `sub_mode` high, and is stored as 0 otherwise. `subtitle_o` shows the stored bit while `sub_mode` is high and 0 while it is low.
- R9: `chapter_o` shows column 7 bits 2..0. Column 7 bits 4..3 have no effect on any output.
- R10: `match_o` and `capture_o` are high only in the cycle after a cycle with `hdr_valid` high.
- R11: Only the digit field takes part in a comparison. The fields are: column 0 bits 2..0 (magazine), columns 1, 2, 4 and 6 bits 3..0, column 3 bits 1..0 (hours tens), and column 5 bits 2..0 (minutes tens). The hold bit, the subtitle bit, column 3 bit 2 and column 5 bit 3 never change `match_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat present; always accepted |
| wr_start | input | 1 | Beat is the first of a burst |
| wr_col | input | 3 | Start column, used when `wr_start` is high |
| wr_data | input | 8 | Write byte; bits 4..0 stored |
| sub_mode | input | 1 | Enables the subtitle bit |
| hdr_valid | input | 1 | Header digits valid this cycle |
| hdr_mag | input | 3 | Header magazine |
| hdr_pg_tens | input | 4 | Header page tens |
| hdr_pg_units | input | 4 | Header page units |
| hdr_hr_tens | input | 2 | Header hours tens |
| hdr_hr_units | input | 4 | Header hours units |
| hdr_mn_tens | input | 3 | Header minutes tens |
| hdr_mn_units | input | 4 | Header minutes units |
| match_o | output | 1 | Header matched the request |
| capture_o | output | 1 | Match with hold bit set |
| subtitle_o | output | 1 | Subtitle flag |
| chapter_o | output | 3 | Chapter address |

## Verification
The bench first checks the state just after reset, where no digit is cared: a header must match there but must not capture. A design that reset the flags to 1, or ignored the hold bit, would fail this check. It runs a burst that overruns column 7 and then reads the chapter output. A pointer that wrapped to column 0 would corrupt the magazine request, and one that kept writing would change the chapter. It sets the hold, subtitle and spare bits that share columns with digits. A design that compared whole columns instead of digit fields would then drop matches. Back-to-back header strobes with different outcomes catch a match flag that is stretched, or that lags by one cycle.

// File: rtl/pgreq_pkg.sv
package pgreq_pkg;
  localparam int NCOL    = 8;
  localparam int COLW    = 5;
  localparam int NDIG    = 7;
  localparam int DIGW    = 4;
  localparam int PTRW    = $clog2(NCOL);
  localparam int CARE_B  = COLW - 1;
  localparam int HOLD_C  = 0;
  localparam int HOLD_B  = 3;
  localparam int SUB_C   = 3;
  localparam int SUB_B   = 3;
  localparam int CHAP_C  = NCOL - 1;
  localparam int CHAPW   = 3;

  // width of the digit held in column c
  function automatic logic [DIGW-1:0] dig_mask(input int c);
    case (c)
      0, 5:    dig_mask = 4'b0111;
      3:       dig_mask = 4'b0011;
      default: dig_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/pgreq_store.sv
module pgreq_store
  import pgreq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic                      wr_start,
  input  logic [PTRW-1:0]           wr_col,
  input  logic [COLW-1:0]           wr_data,
  input  logic                      sub_mode,
  output logic [NCOL-1:0][COLW-1:0] cols
);
  logic [PTRW-1:0] ptr;
  logic            spent;
  logic [PTRW-1:0] tgt;
  logic            wr_ok;
  logic [COLW-1:0] wd;

  always_comb begin
    tgt   = wr_start ? wr_col : ptr;
    wr_ok = wr_valid && (wr_start || !spent);
    wd    = wr_data;
    if (tgt == PTRW'(SUB_C) && !sub_mode) wd[SUB_B] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cols  <= '0;
      ptr   <= '0;
      spent <= 1'b1;
    end else if (wr_ok) begin
      cols[tgt] <= wd;
      if (tgt == PTRW'(NCOL-1)) begin
        spent <= 1'b1;
      end else begin
        ptr   <= tgt + PTRW'(1);
        spent <= 1'b0;
      end
    end
  end

  // R3
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_start && spent) |=> $stable(cols));
  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_start && wr_col != PTRW'(NCOL-1)) |=>
      (!spent && ptr == $past(wr_col) + PTRW'(1)));
  // R8
  sub_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !sub_mode && tgt == PTRW'(SUB_C)) |=> !cols[SUB_C][SUB_B]);
endmodule

// File: rtl/pgreq_cmp.sv
module pgreq_cmp
  import pgreq_pkg::*;
(
  input  logic [NDIG-1:0][COLW-1:0] req,
  input  logic [NDIG-1:0][DIGW-1:0] hdr,
  output logic                      hit
);
  logic [NDIG-1:0] dig_ok;

  for (genvar c = 0; c < NDIG; c++) begin : g_dig
    localparam logic [DIGW-1:0] MSK = dig_mask(c);
    assign dig_ok[c] = !req[c][CARE_B] ||
                       (((req[c][DIGW-1:0] ^ hdr[c]) & MSK) == '0);
  end

  assign hit = &dig_ok;
endmodule

// File: rtl/pgreq_matcher.sv
module pgreq_matcher
  import pgreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       wr_start,
  input  logic [2:0] wr_col,
  input  logic [7:0] wr_data,
  input  logic       sub_mode,
  input  logic       hdr_valid,
  input  logic [2:0] hdr_mag,
  input  logic [3:0] hdr_pg_tens,
  input  logic [3:0] hdr_pg_units,
  input  logic [1:0] hdr_hr_tens,
  input  logic [3:0] hdr_hr_units,
  input  logic [2:0] hdr_mn_tens,
  input  logic [3:0] hdr_mn_units,
  output logic       match_o,
  output logic       capture_o,
  output logic       subtitle_o,
  output logic [2:0] chapter_o
);
  logic [NCOL-1:0][COLW-1:0] cols;
  logic [NDIG-1:0][DIGW-1:0] hdr;
  logic                      hit;
  logic                      hold;
  logic                      unused_ok;

  assign unused_ok = ^{wr_data[7:COLW], cols[CHAP_C][COLW-1:CHAPW]};

  pgreq_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_start (wr_start),
    .wr_col   (wr_col),
    .wr_data  (wr_data[COLW-1:0]),
    .sub_mode (sub_mode),
    .cols     (cols)
  );

  assign hdr = {DIGW'(hdr_mn_units), DIGW'(hdr_mn_tens), DIGW'(hdr_hr_units),
                DIGW'(hdr_hr_tens), DIGW'(hdr_pg_units), DIGW'(hdr_pg_tens),
                DIGW'(hdr_mag)};

  pgreq_cmp u_cmp (
    .req (cols[NDIG-1:0]),
    .hdr (hdr),
    .hit (hit)
  );

  assign hold = cols[HOLD_C][HOLD_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_o   <= 1'b0;
      capture_o <= 1'b0;
    end else begin
      match_o   <= hdr_valid && hit;
      capture_o <= hdr_valid && hit && hold;
    end
  end

  assign subtitle_o = cols[SUB_C][SUB_B] && sub_mode;
  assign chapter_o  = cols[CHAP_C][CHAPW-1:0];

  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o || capture_o) |-> $past(hdr_valid));
  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |-> (match_o && $past(hold)));
  // R6
  miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cols[1][CARE_B] && cols[1][DIGW-1:0] != hdr_pg_tens) |=> !match_o);
endmodule

// File: tb/tb_pgreq_matcher.sv
module tb_pgreq_matcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_start = 1'b0;
  logic [2:0] wr_col = '0;
  logic [7:0] wr_data = '0;
  logic       sub_mode = 1'b0;
  logic       hdr_valid = 1'b0;
  logic [2:0] hdr_mag = '0, hdr_mn_tens = '0;
  logic [3:0] hdr_pg_tens = '0, hdr_pg_units = '0, hdr_hr_units = '0, hdr_mn_units = '0;
  logic [1:0] hdr_hr_tens = '0;
  logic       match_o, capture_o, subtitle_o;
  logic [2:0] chapter_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [4:0] m [8];
  bit spent = 1;
  int ptr = 0;
  typedef struct { int due; bit mt; bit cp; string tag; } exp_t;
  exp_t q [$];

  pgreq_matcher dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic beat(input bit st, input int col, input logic [7:0] d);
    int t;
    @(negedge clk);
    wr_valid = 1; wr_start = st; wr_col = col[2:0]; wr_data = d;
    if (st || !spent) begin
      t = st ? col : ptr;
      m[t] = d[4:0];
      if (t == 3 && !sub_mode) m[3][3] = 1'b0;
      if (t == 7) spent = 1; else begin ptr = t + 1; spent = 0; end
    end
    @(negedge clk);
    wr_valid = 0; wr_start = 0;
  endtask

  function automatic bit model_hit(input int mg, pt, pu, ht, hu, mt, mu);
    int h [7];
    int w [7];
    bit r = 1;
    h = '{mg, pt, pu, ht, hu, mt, mu};
    w = '{7, 15, 15, 3, 15, 7, 15};
    for (int c = 0; c < 7; c++)
      if (m[c][4] && ((int'(m[c][3:0]) & w[c]) != h[c])) r = 0;
    return r;
  endfunction

  // driver: strobe header now, push expected result due after next edge
  task automatic hdr(input int mg, pt, pu, ht, hu, mt, mu, input string tag, input bit hold_beat = 1);
    exp_t e;
    @(negedge clk);
    hdr_valid = 1; hdr_mag = mg[2:0]; hdr_pg_tens = pt[3:0]; hdr_pg_units = pu[3:0];
    hdr_hr_tens = ht[1:0]; hdr_hr_units = hu[3:0]; hdr_mn_tens = mt[2:0]; hdr_mn_units = mu[3:0];
    e.due = cyc + 1;
    e.mt = model_hit(mg, pt, pu, ht, hu, mt, mu);
    e.cp = e.mt && m[0][3];
    e.tag = tag;
    q.push_back(e);
    if (hold_beat) begin
      @(negedge clk);
      hdr_valid = 0;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (q.size() > 0 && q[0].due == cyc) begin
          exp_t e;
          e = q.pop_front();
          chk(match_o == e.mt, {e.tag, " match"}, match_o, e.mt);
          chk(capture_o == e.cp, {e.tag, " capture"}, capture_o, e.cp);
        end else if (match_o || capture_o) begin
          chk(0, "R10 idle pulse", match_o, 0);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(match_o == 0 && capture_o == 0, "R1 reset outputs", match_o, 0);
    chk(subtitle_o == 0 && chapter_o == 0, "R1 reset flags", chapter_o, 0);
    rst_n = 1;
    // R1: nothing cared -> match, hold 0 -> no capture
    hdr(5, 9, 9, 2, 9, 5, 9, "R1 post-reset");
    // R3: beat without start before any burst is dropped
    beat(0, 0, 8'h1F);
    hdr(0, 0, 0, 0, 0, 0, 0, "R3 pre-burst drop");
    // R2/R9: full burst from column 0; junk in bits 7..5 and col7 bits 4..3
    beat(1, 0, 8'hFB); beat(0, 0, 8'h12); beat(0, 0, 8'h15); beat(0, 0, 8'h00);
    beat(0, 0, 8'h00); beat(0, 0, 8'h00); beat(0, 0, 8'h00); beat(0, 0, 8'hFD);
    @(negedge clk); #2;
    chk(chapter_o == 3'd5, "R9 chapter", chapter_o, 5);
    hdr(3, 2, 5, 1, 7, 4, 8, "R4 page match");
    hdr(3, 2, 6, 0, 0, 0, 0, "R6 units miss");
    hdr(4, 2, 5, 0, 0, 0, 0, "R6 magazine miss");
    hdr(3, 2, 5, 3, 3, 3, 3, "R5 uncared time");
    // R3: burst from 6 overruns column 7
    beat(1, 6, 8'h00); beat(0, 0, 8'h02); beat(0, 0, 8'h07); beat(0, 0, 8'h1F);
    @(negedge clk); #2;
    chk(chapter_o == 3'd2, "R3 overrun chapter", chapter_o, 2);
    hdr(3, 2, 5, 0, 0, 0, 0, "R3 overrun no wrap");
    // R7: hold cleared
    beat(1, 0, 8'h13);
    hdr(3, 2, 5, 0, 0, 0, 0, "R7 hold blocks");
    beat(1, 0, 8'h1B);
    // R8/R11: timed request with spare and subtitle bits set, mode low
    beat(1, 3, 8'h1D); beat(0, 0, 8'h12); beat(0, 0, 8'h1B); beat(0, 0, 8'h10);
    @(negedge clk); #2;
    chk(subtitle_o == 0, "R8 subtitle locked", subtitle_o, 0);
    hdr(3, 2, 5, 1, 2, 3, 0, "R11 timed match");
    hdr(3, 2, 5, 1, 2, 3, 1, "R6 minutes miss");
    sub_mode = 1;
    beat(1, 3, 8'h1D);
    @(negedge clk); #2;
    chk(subtitle_o == 1, "R8 subtitle set", subtitle_o, 1);
    hdr(3, 2, 5, 1, 2, 3, 0, "R11 subtitle ignored");
    sub_mode = 0;
    @(negedge clk); #2;
    chk(subtitle_o == 0, "R8 mode low gate", subtitle_o, 0);
    // R10: back-to-back strobes, hit then miss then hit
    hdr(3, 2, 5, 1, 2, 3, 0, "R10 b2b first", 0);
    hdr(3, 2, 5, 2, 2, 3, 0, "R10 b2b second", 0);
    hdr(3, 2, 5, 1, 2, 3, 0, "R10 b2b third");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10 queue drained", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule